// File: doc/BRIEF.md
# Shared Divide and Square-Root Unit Arbiter

This block models the timing of a single long-latency divide and square-root unit that every thread of a core shares. The unit is not pipelined: it holds exactly one operation at a time, and the operation's kind fixes how long it stays. Floating-point divide and square root hold it for a set number of cycles that depends on precision. Integer divide holds it for a time that grows with the size of the dividend. No arithmetic result is produced; the block only decides who runs, when each run ends, and which threads must stall.

Threads are split into two equal groups by index: thread t belongs to group t / (NT/2). Each group keeps its waiting threads in arrival order. When both groups have work, the unit alternates between them, so a group with one waiting thread gets as many turns as a group with four. When only one group has work, its operations run back to back with no idle cycle. A thread raises a one-cycle request with its operation code, precision and dividend. It is then stalled until a one-cycle completion pulse, and it cannot hold more than one operation in flight.

Top module: `divarb_unit`

## Requirements
- R1: After reset, busy_o, done_o and unit_busy_o are all low, and the round-robin pointer favours group 0: if one thread of each group requests in the same cycle, the group 0 thread completes first.
- R2: At most one operation occupies the unit at any time, so at most one bit of done_o is high in a cycle, and every completion comes after a cycle in which unit_busy_o was high.
- R3: A request whose 2-bit code (bits [2t+1:2t] of req_op_i) is not 00 is a floating-point operation: it occupies the unit 19 cycles when req_dbl_i[t] is 0 and 33 cycles when it is 1.
- R4: A request with code 00 is an integer divide: it occupies the unit 12 + n cycles, where n is the position of the highest set bit of the dividend plus one (0 for a zero dividend), capped at 41.
- R5: Within a group, operations start in the order their requests were accepted; requests accepted in the same cycle start in ascending thread order.
- R6: When both groups have waiting operations, starts alternate between the groups; the pointer moves to the group that was not granted only when a grant is made, and is otherwise kept.
- R7: A request from a thread whose busy_o bit is low is accepted, and busy_o for that thread is high from the next cycle until the cycle its done_o bit pulses, in which it is low again; requests from a busy thread are ignored.
- R8: If operations are waiting when one completes, the next one starts at once, so unit_busy_o stays high in the completion cycle.
- R9: With the unit idle and no operation waiting, a request presented in cycle c for an operation of latency L gives its done_o pulse in cycle c + L + 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | NT | One-cycle request per thread |
| req_op_i | input | 2*NT | Operation code per thread, bits [2t+1:2t]; 00 integer divide, others floating point |
| req_dbl_i | input | NT | Double precision flag per thread |
| req_dvd_i | input | NT*DW | Integer dividend per thread, bits [DW*t+DW-1:DW*t] |
| busy_o | output | NT | Thread has an operation accepted and not yet completed |
| done_o | output | NT | One-cycle completion pulse per thread |
| unit_busy_o | output | 1 | The unit holds an operation |

## Verification
The bound checker watches on every cycle that completions are one-hot, that a thread's stall begins after an accepted request and ends only with its own completion pulse, that the unit never idles in a completion cycle while older work waits, and that each operation's occupancy lies inside the legal latency range. What these properties cannot show is which operation runs next and its exact latency: the arrival order inside a group, the alternation between groups with the pointer kept across bursts, and the per-code and per-dividend cycle counts come out only of the bench's directed scenarios and its per-cycle comparison with a queue-based model under random traffic.

// File: rtl/divarb_pkg.sv
package divarb_pkg;

   // operation codes on the per-thread 2-bit code field
   typedef enum logic [1:0] {
      OP_IDIV  = 2'b00,
      OP_FDIV  = 2'b01,
      OP_FSQRT = 2'b10,
      OP_FRSV  = 2'b11
   } div_op_e;

   function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   function automatic int unsigned min3(input int unsigned a, input int unsigned b,
                                        input int unsigned c);
      int unsigned m;
      m = (a < b) ? a : b;
      return (m < c) ? m : c;
   endfunction

endpackage

// File: rtl/divarb_lat.sv
module divarb_lat #(
   parameter int unsigned DW       = 32,
   parameter int unsigned LW       = 6,
   parameter int unsigned INT_BASE = 12,
   parameter int unsigned INT_MAX  = 41,
   parameter int unsigned FP_SGL   = 19,
   parameter int unsigned FP_DBL   = 33
) (
   input  logic [1:0]    op_i,
   input  logic          dbl_i,
   input  logic [DW-1:0] dvd_i,
   output logic [LW-1:0] lat_o
);

   int unsigned sig_n;
   int unsigned ilat;

   // significant-bit count of the dividend
   always_comb begin
      sig_n = 0;
      for (int b = 0; b < DW; b++) begin
         if (dvd_i[b]) sig_n = b + 1;
      end
   end

   always_comb begin
      ilat = INT_BASE + sig_n;
      if (ilat > INT_MAX) ilat = INT_MAX;
      if (op_i == divarb_pkg::OP_IDIV) begin
         lat_o = LW'(ilat);
      end else if (dbl_i) begin
         lat_o = LW'(FP_DBL);
      end else begin
         lat_o = LW'(FP_SGL);
      end
   end

endmodule

// File: rtl/divarb_gfifo.sv
module divarb_gfifo #(
   parameter int unsigned GT  = 4,
   parameter int unsigned LW  = 6,
   localparam int unsigned IDW = $clog2(GT),
   localparam int unsigned CW  = $clog2(GT + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [GT-1:0]    push_i,
   input  logic [GT*LW-1:0] lat_i,
   input  logic             pop_i,
   output logic             vld_o,
   output logic [IDW-1:0]   head_id_o,
   output logic [LW-1:0]    head_lat_o
);

   logic [IDW-1:0] id_q [GT];
   logic [LW-1:0]  lt_q [GT];
   logic [IDW-1:0] id_d [GT];
   logic [LW-1:0]  lt_d [GT];
   logic [CW-1:0]  cnt_q, cnt_d;

   // pop shifts toward the head, then same-cycle pushes land in thread order
   always_comb begin
      id_d  = id_q;
      lt_d  = lt_q;
      cnt_d = cnt_q;
      if (pop_i && (cnt_q != '0)) begin
         for (int k = 0; k < GT - 1; k++) begin
            id_d[k] = id_q[k+1];
            lt_d[k] = lt_q[k+1];
         end
         cnt_d = cnt_d - CW'(1);
      end
      for (int j = 0; j < GT; j++) begin
         if (push_i[j] && (cnt_d < CW'(GT))) begin
            id_d[cnt_d[IDW-1:0]] = IDW'(j);
            lt_d[cnt_d[IDW-1:0]] = lat_i[j*LW +: LW];
            cnt_d = cnt_d + CW'(1);
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         for (int k = 0; k < GT; k++) begin
            id_q[k] <= '0;
            lt_q[k] <= '0;
         end
      end else begin
         cnt_q <= cnt_d;
         id_q  <= id_d;
         lt_q  <= lt_d;
      end
   end

   assign vld_o      = (cnt_q != '0);
   assign head_id_o  = id_q[0];
   assign head_lat_o = lt_q[0];

endmodule

// File: rtl/divarb_core.sv
module divarb_core #(
   parameter int unsigned GT  = 4,
   parameter int unsigned LW  = 6,
   localparam int unsigned IDW = $clog2(GT),
   localparam int unsigned TW  = IDW + 1
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [1:0]            vld_i,
   input  logic [1:0][IDW-1:0]   hid_i,
   input  logic [1:0][LW-1:0]    hlat_i,
   output logic [1:0]            pop_o,
   output logic                  act_o,
   output logic                  fin_o,
   output logic [TW-1:0]         own_o
);

   logic          act_q;
   logic [LW-1:0] rem_q;
   logic [TW-1:0] own_q;
   logic          rr_q;
   logic          free, grant, gsel;

   assign fin_o = act_q && (rem_q == LW'(1));
   assign free  = !act_q || fin_o;
   assign grant = free && (vld_i != 2'b00);
   // both groups waiting: pointer decides; otherwise the only waiting group
   assign gsel  = (vld_i == 2'b11) ? rr_q : vld_i[1];
   assign pop_o = grant ? (gsel ? 2'b10 : 2'b01) : 2'b00;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         act_q <= 1'b0;
         rem_q <= '0;
         own_q <= '0;
         rr_q  <= 1'b0;
      end else if (grant) begin
         act_q <= 1'b1;
         rem_q <= hlat_i[gsel];
         own_q <= {gsel, hid_i[gsel]};
         rr_q  <= ~gsel;
      end else if (fin_o) begin
         act_q <= 1'b0;
      end else if (act_q) begin
         rem_q <= rem_q - LW'(1);
      end
   end

   assign act_o = act_q;
   assign own_o = own_q;

endmodule

// File: rtl/divarb_unit.sv
module divarb_unit #(
   parameter int unsigned NT       = 8,
   parameter int unsigned DW       = 32,
   parameter int unsigned INT_BASE = 12,
   parameter int unsigned INT_MAX  = 41,
   parameter int unsigned FP_SGL   = 19,
   parameter int unsigned FP_DBL   = 33
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [NT-1:0]    req_i,
   input  logic [2*NT-1:0]  req_op_i,
   input  logic [NT-1:0]    req_dbl_i,
   input  logic [NT*DW-1:0] req_dvd_i,
   output logic [NT-1:0]    busy_o,
   output logic [NT-1:0]    done_o,
   output logic             unit_busy_o
);

   localparam int unsigned GT   = NT / 2;
   localparam int unsigned IDW  = $clog2(GT);
   localparam int unsigned TW   = IDW + 1;
   localparam int unsigned LMAX = divarb_pkg::max3(INT_MAX, FP_SGL, FP_DBL);
   localparam int unsigned LW   = $clog2(LMAX + 1);

   if ((NT < 4) || (NT % 2 != 0) || ((1 << IDW) != GT)) begin : g_bad_nt
      $error("divarb_unit: NT must be twice a power of two, at least 4");
   end
   if ((INT_BASE < 1) || (INT_MAX < INT_BASE) || (FP_SGL < 1) || (FP_DBL < 1)) begin : g_bad_lat
      $error("divarb_unit: latencies must be at least one and INT_MAX >= INT_BASE");
   end
   if (DW < 1) begin : g_bad_dw
      $error("divarb_unit: DW must be positive");
   end

   logic [NT-1:0]      busy_q, done_q, acc, clr;
   logic [NT*LW-1:0]   lat_flat;
   logic [1:0]         g_vld, g_pop;
   logic [1:0][IDW-1:0] g_hid;
   logic [1:0][LW-1:0] g_hlat;
   logic               act, fin;
   logic [TW-1:0]      own;

   assign acc = req_i & ~busy_q;

   for (genvar t = 0; t < NT; t++) begin : g_thr
      divarb_lat #(
         .DW(DW), .LW(LW), .INT_BASE(INT_BASE), .INT_MAX(INT_MAX),
         .FP_SGL(FP_SGL), .FP_DBL(FP_DBL)
      ) u_lat (
         .op_i (req_op_i[2*t +: 2]),
         .dbl_i(req_dbl_i[t]),
         .dvd_i(req_dvd_i[DW*t +: DW]),
         .lat_o(lat_flat[LW*t +: LW])
      );
   end

   for (genvar g = 0; g < 2; g++) begin : g_grp
      divarb_gfifo #(.GT(GT), .LW(LW)) u_fifo (
         .clk_i     (clk_i),
         .rst_ni    (rst_ni),
         .push_i    (acc[g*GT +: GT]),
         .lat_i     (lat_flat[g*GT*LW +: GT*LW]),
         .pop_i     (g_pop[g]),
         .vld_o     (g_vld[g]),
         .head_id_o (g_hid[g]),
         .head_lat_o(g_hlat[g])
      );
   end

   divarb_core #(.GT(GT), .LW(LW)) u_core (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .vld_i (g_vld),
      .hid_i (g_hid),
      .hlat_i(g_hlat),
      .pop_o (g_pop),
      .act_o (act),
      .fin_o (fin),
      .own_o (own)
   );

   always_comb begin
      clr      = '0;
      clr[own] = fin;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         busy_q <= '0;
         done_q <= '0;
      end else begin
         busy_q <= (busy_q | acc) & ~clr;
         done_q <= clr;
      end
   end

   assign busy_o      = busy_q;
   assign done_o      = done_q;
   assign unit_busy_o = act;

endmodule

// File: rtl/divarb_unit_chk.sv
module divarb_unit_chk #(
   parameter int unsigned NT       = 8,
   parameter int unsigned INT_BASE = 12,
   parameter int unsigned INT_MAX  = 41,
   parameter int unsigned FP_SGL   = 19,
   parameter int unsigned FP_DBL   = 33
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic [NT-1:0] req_i,
   input logic [NT-1:0] busy_o,
   input logic [NT-1:0] done_o,
   input logic          unit_busy_o
);

   localparam int unsigned LMIN = divarb_pkg::min3(INT_BASE, FP_SGL, FP_DBL);
   localparam int unsigned LMAX = divarb_pkg::max3(INT_MAX, FP_SGL, FP_DBL);

   int unsigned occ;

   // cycles the current operation has held the unit
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) occ <= 0;
      else if (done_o != '0) occ <= unit_busy_o ? 1 : 0;
      else if (unit_busy_o) occ <= occ + 1;
   end

   // R2
   one_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(done_o));

   // R2
   done_after_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o != '0) |-> $past(unit_busy_o));

   // R8
   no_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((done_o != '0) && ((busy_o & $past(busy_o)) != '0)) |-> unit_busy_o);

   // R3 R4
   lat_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (done_o != '0) |-> ((occ >= LMIN) && (occ <= LMAX)));

   for (genvar i = 0; i < NT; i++) begin : g_thr
      // R7
      busy_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (req_i[i] && !busy_o[i]) |=> busy_o[i]);
      // R7
      busy_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $fell(busy_o[i]) |-> done_o[i]);
      // R7
      done_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         done_o[i] |-> $past(busy_o[i]));
   end

endmodule

bind divarb_unit divarb_unit_chk #(
   .NT(NT), .INT_BASE(INT_BASE), .INT_MAX(INT_MAX), .FP_SGL(FP_SGL), .FP_DBL(FP_DBL)
) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .req_i      (req_i),
   .busy_o     (busy_o),
   .done_o     (done_o),
   .unit_busy_o(unit_busy_o)
);

// File: tb/divarb_unit_bench.sv
`timescale 1ns/1ps
module divarb_unit_bench;
   localparam int NT = 8;
   localparam int DW = 32;
   localparam int GT = NT / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic [NT-1:0]    req = '0;
   logic [2*NT-1:0]  op = '0;
   logic [NT-1:0]    dbl = '0;
   logic [NT*DW-1:0] dvd = '0;
   logic [NT-1:0]    busy, done;
   logic             ubusy;

   divarb_unit u_divarb_unit (
      .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_op_i(op), .req_dbl_i(dbl),
      .req_dvd_i(dvd), .busy_o(busy), .done_o(done), .unit_busy_o(ubusy)
   );

   int    checks = 0;
   int    fails = 0;
   bit    over = 0;
   string cur_req = "R2";

   task automatic chk(input bit ok, input string r, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          q0[$], q1[$];
   int          m_lat[NT];
   logic [NT-1:0] m_busy, m_done;
   bit          m_act;
   int          m_rem, m_own, m_rr;

   function automatic int ref_lat(input int t);
      logic [DW-1:0] v;
      int n, l;
      if (op[2*t +: 2] == 2'b00) begin
         v = dvd[DW*t +: DW];
         n = 0;
         while (v != 0) begin v = v >> 1; n++; end
         l = 12 + n;
         if (l > 41) l = 41;
      end else begin
         l = dbl[t] ? 33 : 19;
      end
      return l;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q0.delete(); q1.delete();
         m_busy = '0; m_done = '0; m_act = 0; m_rem = 0; m_own = 0; m_rr = 0;
      end else begin
         logic [NT-1:0] pre;
         bit fin, free;
         int g, t;
         pre = m_busy;
         fin = m_act && (m_rem == 1);
         free = !m_act || fin;
         m_done = '0;
         if (fin) begin m_done[m_own] = 1'b1; m_busy[m_own] = 1'b0; end
         g = -1;
         if (free) begin
            if (q0.size() > 0 && q1.size() > 0) g = m_rr;
            else if (q0.size() > 0) g = 0;
            else if (q1.size() > 0) g = 1;
         end
         if (g >= 0) begin
            t = (g == 0) ? q0.pop_front() : q1.pop_front();
            m_act = 1; m_rem = m_lat[t]; m_own = t; m_rr = 1 - g;
         end else if (fin) m_act = 0;
         else if (m_act) m_rem--;
         for (int k = 0; k < NT; k++) begin
            if (req[k] && !pre[k]) begin
               m_lat[k] = ref_lat(k);
               if (k < GT) q0.push_back(k); else q1.push_back(k);
               m_busy[k] = 1'b1;
            end
         end
      end
   end

   // ---------------- per-cycle comparison and completion log ----------------
   int done_log[$];
   always @(negedge clk) begin
      if (rst_n && !over) begin
         chk(busy == m_busy, cur_req, "busy_o", busy, m_busy);
         chk(done == m_done, cur_req, "done_o", done, m_done);
         chk(ubusy == m_act, cur_req, "unit_busy_o", ubusy, m_act);
         for (int k = 0; k < NT; k++) if (done[k]) done_log.push_back(k);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic issue(input logic [NT-1:0] mask, input logic [1:0] o, input bit d,
                        input logic [DW-1:0] v);
      @(negedge clk);
      for (int k = 0; k < NT; k++) if (mask[k]) begin
         op[2*k +: 2] = o; dbl[k] = d; dvd[DW*k +: DW] = v;
      end
      req = mask;
      @(negedge clk);
      req = '0;
   endtask

   task automatic wait_idle();
      int n;
      n = 0;
      do begin @(negedge clk); n++; end
      while ((busy != '0 || ubusy || done != '0) && n < 2000);
   endtask

   task automatic probe(input int t, input logic [1:0] o, input bit d,
                        input logic [DW-1:0] v, input int exp_l, input string r);
      int n;
      wait_idle();
      @(negedge clk);
      op[2*t +: 2] = o; dbl[t] = d; dvd[DW*t +: DW] = v;
      req[t] = 1'b1;
      n = 0;
      do begin @(negedge clk); req = '0; n++; end while (!done[t] && n < 200);
      chk(n == exp_l + 2, r, "cycles request-to-done", n, exp_l + 2);
   endtask

   task automatic check_order(input int exp[$], input string r);
      chk(done_log.size() == exp.size(), r, "completion count", done_log.size(), exp.size());
      foreach (exp[i]) begin
         if (i < done_log.size())
            chk(done_log[i] == exp[i], r, "completion order", done_log[i], exp[i]);
      end
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(4ns * 150000);
      if (!over) begin
         over = 1;
         checks++; fails++;
         $display("FAIL watchdog run did not finish actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- scenarios ----------------
   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(busy == '0, "R1", "busy_o after reset", busy, 0);
      chk(done == '0, "R1", "done_o after reset", done, 0);
      chk(ubusy == 1'b0, "R1", "unit_busy_o after reset", ubusy, 0);

      // R1: pointer starts at group 0
      cur_req = "R1";
      done_log.delete();
      issue(8'h11, 2'b01, 1'b0, '0);
      wait_idle();
      check_order('{0, 4}, "R1");

      // R6: alternation with unequal group loads (pointer now at group 0)
      cur_req = "R6";
      done_log.delete();
      issue(8'h37, 2'b01, 1'b0, '0);
      wait_idle();
      check_order('{0, 4, 1, 5, 2}, "R6");
      // R6: pointer kept across idle: last grant was group 0, so group 1 leads
      done_log.delete();
      issue(8'hC1, 2'b10, 1'b0, '0);
      wait_idle();
      check_order('{6, 0, 7}, "R6");

      // R5: same-cycle and later arrivals inside one group
      cur_req = "R5";
      done_log.delete();
      issue(8'h08, 2'b01, 1'b0, '0);
      issue(8'h05, 2'b01, 1'b0, '0);
      wait_idle();
      check_order('{3, 0, 2}, "R5");

      // R7: repeat request from a busy thread is ignored
      cur_req = "R7";
      done_log.delete();
      issue(8'h40, 2'b00, 1'b0, 32'h0);
      chk(busy[6] == 1'b1, "R7", "busy_o[6] while held", busy[6], 1);
      issue(8'h40, 2'b01, 1'b1, '0);
      chk(busy[6] == 1'b1, "R7", "busy_o[6] after ignored request", busy[6], 1);
      wait_idle();
      check_order('{6}, "R7");

      // R8: back-to-back service without an idle cycle
      cur_req = "R8";
      issue(8'h02, 2'b01, 1'b0, '0);
      issue(8'h04, 2'b01, 1'b0, '0);
      begin
         int n;
         n = 0;
         while (!done[1] && n < 200) begin @(negedge clk); n++; end
         chk(ubusy == 1'b1, "R8", "unit_busy_o in completion cycle", ubusy, 1);
      end
      wait_idle();

      // R3 R4 R9: latencies measured from request to completion
      cur_req = "R9";
      probe(0, 2'b01, 1'b0, '0, 19, "R3");
      probe(1, 2'b10, 1'b1, '0, 33, "R3");
      probe(5, 2'b11, 1'b0, '0, 19, "R3");
      probe(2, 2'b00, 1'b0, 32'h0, 12, "R4");
      probe(3, 2'b00, 1'b0, 32'h5, 15, "R4");
      probe(4, 2'b00, 1'b0, 32'h0000_FFFF, 28, "R4");
      probe(7, 2'b00, 1'b1, 32'h8000_0000, 41, "R4");
      probe(6, 2'b01, 1'b1, '0, 33, "R9");

      // R2: random traffic against the model
      cur_req = "R2";
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         for (int k = 0; k < NT; k++) begin
            op[2*k +: 2] = 2'($urandom_range(0, 3));
            dbl[k] = 1'($urandom_range(0, 1));
            dvd[DW*k +: DW] = $urandom() >> $urandom_range(0, 31);
         end
         req = ($urandom_range(0, 3) == 0) ? NT'($urandom()) : '0;
      end
      @(negedge clk);
      req = '0;
      wait_idle();

      if (!over) begin
         over = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule